// File: doc/BRIEF.md
# Unequal-Set Second-Level Page Translation Cache

This block is a second-level translation cache for 2 MB pages. It holds virtual page number to physical page number pairs in seven sets whose capacities differ. One large set holds 17 entries and six small sets hold 8 entries each. That gives 65 entries, which cover about 130 MB of address space. As a working set grows, misses therefore rise in steps rather than along a straight line.

A lookup presents a virtual page number and receives a registered hit flag and physical page number one cycle later. After a miss, the page-walk side installs the translation with a fill request. The target set is chosen by the page number modulo 7. Inside a set, a fill takes a free entry if one exists, and otherwise the least recently used one. A flush input empties the whole structure.

Top module: `uneq_tlb`

## Requirements
- R1: After reset, and in every cycle after a flush, every entry is invalid, so any lookup reports a miss. Right after reset the response outputs are all zero.
- R2: A lookup request registered on one clock edge produces `rsp_valid` high in the following cycle only. When there is no request, `rsp_valid` is low.
- R3: A response that misses carries `rsp_ppn` equal to zero.
- R4: The page number is the address above bit 20. Its set is the page number modulo 7. Set 0 holds 17 entries and sets 1 to 6 hold 8 entries each.
- R5: After a fill of a page number, a later lookup of that page number hits and returns the filled physical page number.
- R6: A set keeps as many distinct page numbers as its capacity. One more fill into a full set evicts exactly one entry, the least recently used, and the new page hits.
- R7: A lookup hit makes its entry the most recently used, so it outlives entries that were filled after it but not touched since.
- R8: A fill of a page number that is already resident overwrites that entry's physical page number in place. It evicts nothing.
- R9: Sets are independent: fills into one set never remove entries of another set.
- R10: A lookup presented in the same cycle as a flush reports a miss. A fill presented in the same cycle as a flush is dropped.
- R11: A lookup and a fill in the same cycle: the lookup is answered from the contents before the fill, and the fill is still installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VA_W-21 | Virtual page number to translate |
| fill_valid | input | 1 | Fill request from the page walker |
| fill_vpn | input | VA_W-21 | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| rsp_valid | output | 1 | Registered: a lookup was made last cycle |
| rsp_hit | output | 1 | Registered: that lookup hit |
| rsp_ppn | output | PPN_W | Registered physical page number, zero on a miss |

## Verification
The properties assume that reset is held with `flush`, `lk_valid` and `fill_valid` low. They also assume that the fill port only installs page numbers the walker actually translated. No input is ever unknown after time zero. The bench drives every input from a known value at time zero, keeps all requests low during reset, and changes inputs only on falling edges. Capacity and recency cases use page numbers chosen as fixed residues modulo 7, including values near the top of the page-number range, so each case targets one known set.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int unsigned PAGE_SHIFT = 21;

  function automatic int unsigned set_ways(input int unsigned s, input int unsigned big_set,
                                           input int unsigned big_ways,
                                           input int unsigned small_ways);
    return (s == big_set) ? big_ways : small_ways;
  endfunction
endpackage

// File: rtl/utlb_set_map.sv
module utlb_set_map #(
  parameter int unsigned VPN_W    = 19,
  parameter int unsigned NUM_SETS = 7,
  parameter int unsigned SET_W    = 3
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [SET_W-1:0] set_idx
);
  generate
    if (NUM_SETS == 7) begin : g_fold7
      // 8 = 1 (mod 7): summing 3-bit digits preserves the residue.
      localparam int unsigned CHUNKS = (VPN_W + 2) / 3;
      localparam int unsigned PAD_W  = CHUNKS * 3;
      logic [PAD_W-1:0] padded;
      logic [7:0]       acc;
      assign padded = PAD_W'(vpn);
      always_comb begin
        acc = '0;
        for (int i = 0; i < CHUNKS; i++) acc = acc + {5'b0, padded[3*i +: 3]};
        for (int f = 0; f < 5; f++) acc = {3'b0, acc[7:3]} + {5'b0, acc[2:0]};
        set_idx = (acc[2:0] == 3'd7) ? SET_W'(0) : SET_W'(acc[2:0]);
      end
    end else begin : g_generic
      assign set_idx = SET_W'(vpn % VPN_W'(NUM_SETS));
    end
  endgenerate
endmodule

// File: rtl/utlb_set_bank.sv
module utlb_set_bank #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned VPN_W = 19,
  parameter int unsigned PPN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  localparam int unsigned IDX_W = $clog2(WAYS);
  localparam int unsigned AGE_W = $clog2(WAYS);
  localparam logic [AGE_W:0] OLDEST = (AGE_W+1)'(WAYS - 1);
  localparam logic [AGE_W:0] BEYOND = (AGE_W+1)'(WAYS);

  logic [WAYS-1:0]  valid_q;
  logic [VPN_W-1:0] tag_q [WAYS];
  logic [PPN_W-1:0] ppn_q [WAYS];
  logic [AGE_W-1:0] age_q [WAYS];

  logic [WAYS-1:0] lk_match, fill_match;
  logic [IDX_W-1:0] hit_idx, same_idx, free_idx, old_idx, victim;
  logic fill_same, free_any;
  logic touch_en;
  logic [IDX_W-1:0] touch_idx;
  logic [AGE_W:0]   touch_lim;

  always_comb begin
    hit_ppn  = '0;
    hit_idx  = '0;
    same_idx = '0;
    free_idx = '0;
    old_idx  = '0;
    free_any = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      lk_match[i]   = valid_q[i] && (tag_q[i] == lk_vpn);
      fill_match[i] = valid_q[i] && (tag_q[i] == fill_vpn);
      if (lk_match[i])   hit_idx  = IDX_W'(i);
      if (fill_match[i]) same_idx = IDX_W'(i);
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
      if (valid_q[i] && ({1'b0, age_q[i]} == OLDEST)) old_idx = IDX_W'(i);
      if (lk_match[i]) hit_ppn = hit_ppn | ppn_q[i];
    end
    hit       = lk_en && (|lk_match);
    if (!hit) hit_ppn = '0;
    fill_same = |fill_match;
    victim    = fill_same ? same_idx : (free_any ? free_idx : old_idx);
  end

  always_comb begin
    touch_en  = 1'b0;
    touch_idx = '0;
    touch_lim = '0;
    if (fill_en) begin
      touch_en  = 1'b1;
      touch_idx = victim;
      touch_lim = valid_q[victim] ? {1'b0, age_q[victim]} : BEYOND;
    end else if (hit) begin
      touch_en  = 1'b1;
      touch_idx = hit_idx;
      touch_lim = {1'b0, age_q[hit_idx]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      for (int i = 0; i < WAYS; i++) age_q[i] <= '0;
    end else begin
      if (fill_en) begin
        valid_q[victim] <= 1'b1;
        tag_q[victim]   <= fill_vpn;
        ppn_q[victim]   <= fill_ppn;
      end
      if (touch_en) begin
        for (int i = 0; i < WAYS; i++) begin
          if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
          else if (valid_q[i] && ({1'b0, age_q[i]} < touch_lim)) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uneq_tlb.sv
module uneq_tlb #(
  parameter int unsigned VA_W       = 40,
  parameter int unsigned PPN_W      = 16,
  parameter int unsigned NUM_SETS   = 7,
  parameter int unsigned BIG_SET    = 0,
  parameter int unsigned BIG_WAYS   = 17,
  parameter int unsigned SMALL_WAYS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  flush,
  input  logic                                  lk_valid,
  input  logic [VA_W-utlb_pkg::PAGE_SHIFT-1:0]  lk_vpn,
  input  logic                                  fill_valid,
  input  logic [VA_W-utlb_pkg::PAGE_SHIFT-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]                      fill_ppn,
  output logic                                  rsp_valid,
  output logic                                  rsp_hit,
  output logic [PPN_W-1:0]                      rsp_ppn
);
  localparam int unsigned VPN_W = VA_W - utlb_pkg::PAGE_SHIFT;
  localparam int unsigned SET_W = $clog2(NUM_SETS);

  logic [SET_W-1:0] lk_set, fill_set;
  logic [NUM_SETS-1:0] hit_vec;
  logic [PPN_W-1:0]    bank_ppn [NUM_SETS];
  logic [PPN_W-1:0]    ppn_any;

  utlb_set_map #(.VPN_W(VPN_W), .NUM_SETS(NUM_SETS), .SET_W(SET_W)) lk_map_i (
    .vpn(lk_vpn), .set_idx(lk_set));
  utlb_set_map #(.VPN_W(VPN_W), .NUM_SETS(NUM_SETS), .SET_W(SET_W)) fill_map_i (
    .vpn(fill_vpn), .set_idx(fill_set));

  generate
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam int unsigned W = utlb_pkg::set_ways(s, BIG_SET, BIG_WAYS, SMALL_WAYS);
      logic lk_en, fill_en;
      assign lk_en   = lk_valid && !flush && (lk_set == SET_W'(s));
      assign fill_en = fill_valid && !flush && (fill_set == SET_W'(s));
      utlb_set_bank #(.WAYS(W), .VPN_W(VPN_W), .PPN_W(PPN_W)) bank_i (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_en(lk_en), .lk_vpn(lk_vpn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .hit(hit_vec[s]), .hit_ppn(bank_ppn[s]));
    end
  endgenerate

  always_comb begin
    ppn_any = '0;
    for (int s = 0; s < NUM_SETS; s++) ppn_any = ppn_any | bank_ppn[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= |hit_vec;
      rsp_ppn   <= ppn_any;
    end
  end
endmodule

// File: rtl/uneq_tlb_chk.sv
module uneq_tlb_chk #(
  parameter int unsigned VPN_W    = 19,
  parameter int unsigned PPN_W    = 16,
  parameter int unsigned NUM_SETS = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic [NUM_SETS-1:0] hit_vec
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  a_r3_miss_ppn_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));
  a_r2_hit_needs_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  a_r4_single_set_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  a_r10_flush_lookup_miss: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_valid) |=> !rsp_hit);
  a_r1_after_flush_miss: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && !$past(rst) && lk_valid) |=> !rsp_hit);
  a_r5_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid && !flush && !rst) && lk_valid && !flush && (lk_vpn == $past(fill_vpn)))
      |=> (rsp_hit && (rsp_ppn == $past(fill_ppn, 2))));
endmodule

bind uneq_tlb uneq_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .NUM_SETS(NUM_SETS)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .hit_vec(hit_vec));

// File: tb/uneq_tlb_tb_top.sv
module uneq_tlb_tb_top;
  localparam int VPN_W = 19;
  localparam int PPN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  uneq_tlb dut_i (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn));

  // {fill, vpn, ppn, expected hit}
  localparam logic [36:0] VEC [8] = '{
    {1'b1, 19'd10,     16'h00A1, 1'b1},
    {1'b1, 19'd11,     16'h00B2, 1'b1},
    {1'b1, 19'h40000,  16'h0C03, 1'b1},
    {1'b0, 19'd17,     16'h0000, 1'b0},
    {1'b1, 19'd21,     16'h0D04, 1'b1},
    {1'b1, 19'h7FFFF,  16'h0E05, 1'b1},
    {1'b0, 19'd3,      16'h0000, 1'b0},
    {1'b0, 19'd10,     16'h00A1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] v,
                      input logic eh, input logic [PPN_W-1:0] ep);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(eh));
    check({req, " ppn"}, 32'(rsp_ppn), 32'(eh ? ep : '0));
  endtask

  function automatic logic [VPN_W-1:0] va(input int k);
    return VPN_W'(524287 - 7 * k);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R1 reset rsp_hit", 32'(rsp_hit), 0);
    check("R1 reset rsp_ppn", 32'(rsp_ppn), 0);
    look("R1 R3 empty lookup", 19'd5, 1'b0, '0);
    @(negedge clk);
    check("R2 idle rsp_valid", 32'(rsp_valid), 0);

    // R5 R3 table walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][36]) do_fill(VEC[i][35:17], VEC[i][16:1]);
      look("R5 table", VEC[i][35:17], VEC[i][0], VEC[i][16:1]);
    end
    do_flush();
    look("R1 after flush", 19'd10, 1'b0, '0);

    // Small set 1 with large page numbers: R4 R6 R8
    do_flush();
    for (int k = 0; k < 8; k++) do_fill(va(k), PPN_W'(16'h300 + k));
    do_fill(va(2), 16'h03FF);
    for (int k = 0; k < 8; k++)
      look("R8 R6 set1 resident", va(k), 1'b1, (k == 2) ? 16'h03FF : PPN_W'(16'h300 + k));
    do_fill(va(8), 16'h0308);
    look("R6 set1 lru evicted", va(0), 1'b0, '0);
    look("R6 set1 new hit", va(8), 1'b1, 16'h0308);
    look("R4 set1 other kept", va(1), 1'b1, 16'h0301);

    // Large set 0: R4 R6
    do_flush();
    for (int k = 1; k <= 17; k++) do_fill(VPN_W'(7 * k), PPN_W'(16'h200 + k));
    for (int k = 1; k <= 17; k++) look("R4 set0 holds 17", VPN_W'(7 * k), 1'b1, PPN_W'(16'h200 + k));
    do_fill(VPN_W'(126), 16'h0212);
    look("R6 set0 lru evicted", 19'd7, 1'b0, '0);
    look("R6 set0 new hit", 19'd126, 1'b1, 16'h0212);
    look("R6 set0 other kept", 19'd14, 1'b1, 16'h0202);

    // Recency and set independence: R7 R9
    do_flush();
    do_fill(19'd4, 16'h0044);
    for (int k = 0; k < 8; k++) do_fill(VPN_W'(7 * k + 5), PPN_W'(16'h500 + k));
    look("R7 refresh", 19'd5, 1'b1, 16'h0500);
    do_fill(VPN_W'(61), 16'h0508);
    look("R7 refreshed kept", 19'd5, 1'b1, 16'h0500);
    look("R7 next oldest evicted", 19'd12, 1'b0, '0);
    look("R7 new hit", 19'd61, 1'b1, 16'h0508);
    look("R9 other set kept", 19'd4, 1'b1, 16'h0044);

    // R10 flush with lookup / fill
    do_fill(19'd30, 16'h0030);
    @(negedge clk);
    flush = 1'b1; lk_valid = 1'b1; lk_vpn = 19'd30;
    @(negedge clk);
    flush = 1'b0; lk_valid = 1'b0;
    check("R10 flush lookup valid", 32'(rsp_valid), 1);
    check("R10 flush lookup miss", 32'(rsp_hit), 0);
    look("R10 flushed entry", 19'd30, 1'b0, '0);
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 19'd31; fill_ppn = 16'h0031;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look("R10 fill dropped", 19'd31, 1'b0, '0);

    // R11 lookup and fill together
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 19'd40;
    fill_valid = 1'b1; fill_vpn = 19'd40; fill_ppn = 16'h0077;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    check("R11 same-cycle old contents", 32'(rsp_hit), 0);
    look("R11 fill installed", 19'd40, 1'b1, 16'h0077);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule